// File: doc/BRIEF.md
# Per-Set Way Allocation Adjuster

This block holds, for every set of a shared set-associative cache, how many ways each of several cores may occupy. Two saturating event counters per core per set are fed by strobes from the cache: one for hits that landed in the least-recently-used position of the core's share, one for far misses (misses that more ways would have turned into hits). Far-miss detection itself sits outside the block; such events simply arrive on a strobe.

An epoch pulse starts a sweep that visits one set per cycle in ascending index order. For the visited set the block scores each core. The hits it would gain from one more way are far_misses × (ASSOC − ways). The hits it would lose by giving one way up are lru_hits × ASSOC. The block picks a receiver and a donor with a linear scan. It moves a single way only when that raises the expected hit count, then clears that set's counters. The replacement logic reads the resulting table through a combinational read port.

Top module: `way_alloc_adjuster`

## Requirements
- R1: After reset every set gives each core ASSOC/NUM_CORES ways, plus one extra way to each of the lowest-numbered cores while the remainder ASSOC mod NUM_CORES lasts (defaults: 8 ways to each of 4 cores).
- R2: Each event counter is 8 bits wide and holds at 255 instead of wrapping.
- R3: For the visited set, scaled gain is far × (ASSOC − ways) and scaled loss is lru × ASSOC. A way moves only when the receiver's gain is strictly greater than the donor's loss.
- R4: The receiver is the core with the largest gain; ties go to the lowest index. The donor is the core other than the receiver with the smallest loss; ties go to the lowest index.
- R5: No move happens when the chosen donor holds only one way. No core ever holds fewer than one way.
- R6: A decision changes any core's allocation by at most one way, and each set's allocations always sum to ASSOC.
- R7: When a set is visited, both counters of every core in that set are cleared. A strobe that targets the visited set in that same cycle is dropped.
- R8: An epoch pulse while idle raises busy_o on the next edge. Sets 0 to NUM_SETS−1 are then decided one per cycle, with busy_o high for exactly NUM_SETS cycles. An epoch pulse while busy is ignored, and the table changes only on sweep cycles.
- R9: rd_alloc_o combinationally shows the allocation of set rd_set_i, with core c in bits [c*6 +: 6]. Events and decisions in one set leave every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lru_hit_vld_i | input | 1 | Strobe: hit in the core's LRU position |
| lru_hit_set_i | input | 4 | Set index of the LRU-position hit |
| lru_hit_core_i | input | 2 | Core id of the LRU-position hit |
| far_miss_vld_i | input | 1 | Strobe: far miss |
| far_miss_set_i | input | 4 | Set index of the far miss |
| far_miss_core_i | input | 2 | Core id of the far miss |
| epoch_i | input | 1 | Starts a decision sweep |
| busy_o | output | 1 | Sweep in progress |
| rd_set_i | input | 4 | Set index for the read port |
| rd_alloc_o | output | 24 | Ways per core for set rd_set_i, 6 bits per core |

## Verification
On every cycle the assertions check the invariants of the read set: the allocations sum to ASSOC, every core keeps at least one way, and no core moves by more than one way between cycles. They also check that the table holds still outside a sweep and that a sweep never runs longer than NUM_SETS cycles. The choice of receiver and donor, the strict-greater rule, tie ordering, saturation of the counters and dropping of a strobe to the visited set depend on sequences of events. Only the bench's scenarios can show these, and its reference model compares the read port and busy_o on each clock.

// File: rtl/way_alloc_pkg.sv
package way_alloc_pkg;

  typedef enum logic {
    SWEEP_IDLE = 1'b0,
    SWEEP_RUN  = 1'b1
  } sweep_st_e;

  // even split, remainder to low cores
  function automatic int share_of(input int core, input int ncores, input int assoc);
    return assoc / ncores + ((core < (assoc % ncores)) ? 1 : 0);
  endfunction

endpackage

// File: rtl/evt_cnt_bank.sv
module evt_cnt_bank #(
  parameter int NUM_SETS  = 16,
  parameter int NUM_CORES = 4,
  parameter int CNT_W     = 8,
  localparam int SET_W    = $clog2(NUM_SETS),
  localparam int CORE_W   = $clog2(NUM_CORES)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              inc_vld_i,
  input  logic [SET_W-1:0]                  inc_set_i,
  input  logic [CORE_W-1:0]                 inc_core_i,
  input  logic                              clr_vld_i,
  input  logic [SET_W-1:0]                  clr_set_i,
  output logic [NUM_CORES-1:0][CNT_W-1:0]   sel_cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q [NUM_SETS][NUM_CORES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int c = 0; c < NUM_CORES; c++)
          cnt_q[s][c] <= '0;
    end else begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int c = 0; c < NUM_CORES; c++) begin
          if (clr_vld_i && clr_set_i == SET_W'(s)) begin
            cnt_q[s][c] <= '0;  // clear beats a same-cycle strobe
          end else if (inc_vld_i && inc_set_i == SET_W'(s) &&
                       inc_core_i == CORE_W'(c) && cnt_q[s][c] != CNT_MAX) begin
            cnt_q[s][c] <= cnt_q[s][c] + 1'b1;
          end
        end
      end
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_sel
    assign sel_cnt_o[c] = cnt_q[clr_set_i][c];
  end

endmodule

// File: rtl/way_move_select.sv
module way_move_select #(
  parameter int NUM_CORES = 4,
  parameter int ASSOC     = 32,
  parameter int CNT_W     = 8,
  localparam int WAY_W    = $clog2(ASSOC + 1),
  localparam int CORE_W   = $clog2(NUM_CORES),
  localparam int PROD_W   = CNT_W + WAY_W
) (
  input  logic [NUM_CORES-1:0][WAY_W-1:0] ways_i,
  input  logic [NUM_CORES-1:0][CNT_W-1:0] lru_i,
  input  logic [NUM_CORES-1:0][CNT_W-1:0] far_i,
  output logic                            move_vld_o,
  output logic [CORE_W-1:0]               recv_o,
  output logic [CORE_W-1:0]               donor_o
);

  localparam logic [WAY_W-1:0] ASSOC_W = WAY_W'(ASSOC);

  logic [NUM_CORES-1:0][PROD_W-1:0] gain;
  logic [NUM_CORES-1:0][PROD_W-1:0] loss;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_score
    assign gain[c] = PROD_W'(far_i[c]) * PROD_W'(ASSOC_W - ways_i[c]);
    assign loss[c] = PROD_W'(lru_i[c]) * PROD_W'(ASSOC_W);
  end

  logic [PROD_W-1:0] best_gain, best_loss;
  logic              donor_found;

  always_comb begin
    recv_o    = '0;
    best_gain = gain[0];
    for (int c = 1; c < NUM_CORES; c++) begin
      if (gain[c] > best_gain) begin
        best_gain = gain[c];
        recv_o    = CORE_W'(c);
      end
    end
  end

  always_comb begin
    donor_o     = '0;
    best_loss   = '0;
    donor_found = 1'b0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (CORE_W'(c) != recv_o && (!donor_found || loss[c] < best_loss)) begin
        best_loss   = loss[c];
        donor_o     = CORE_W'(c);
        donor_found = 1'b1;
      end
    end
  end

  assign move_vld_o = donor_found && (best_gain > best_loss) &&
                      (ways_i[donor_o] > WAY_W'(1));

endmodule

// File: rtl/alloc_table.sv
module alloc_table #(
  parameter int NUM_SETS  = 16,
  parameter int NUM_CORES = 4,
  parameter int ASSOC     = 32,
  localparam int SET_W    = $clog2(NUM_SETS),
  localparam int CORE_W   = $clog2(NUM_CORES),
  localparam int WAY_W    = $clog2(ASSOC + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              upd_vld_i,
  input  logic [SET_W-1:0]                  upd_set_i,
  input  logic [CORE_W-1:0]                 recv_i,
  input  logic [CORE_W-1:0]                 donor_i,
  output logic [NUM_CORES-1:0][WAY_W-1:0]   upd_ways_o,
  input  logic [SET_W-1:0]                  rd_set_i,
  output logic [NUM_CORES-1:0][WAY_W-1:0]   rd_ways_o
);

  logic [WAY_W-1:0] ways_q [NUM_SETS][NUM_CORES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int c = 0; c < NUM_CORES; c++)
          ways_q[s][c] <= WAY_W'(way_alloc_pkg::share_of(c, NUM_CORES, ASSOC));
    end else if (upd_vld_i) begin
      ways_q[upd_set_i][recv_i]  <= ways_q[upd_set_i][recv_i] + 1'b1;
      ways_q[upd_set_i][donor_i] <= ways_q[upd_set_i][donor_i] - 1'b1;
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_rd
    assign upd_ways_o[c] = ways_q[upd_set_i][c];
    assign rd_ways_o[c]  = ways_q[rd_set_i][c];
  end

endmodule

// File: rtl/way_alloc_adjuster.sv
module way_alloc_adjuster #(
  parameter int NUM_SETS  = 16,
  parameter int NUM_CORES = 4,
  parameter int ASSOC     = 32,
  parameter int CNT_W     = 8
) (
  input  logic                                         clk_i,
  input  logic                                         rst_ni,
  input  logic                                         lru_hit_vld_i,
  input  logic [$clog2(NUM_SETS)-1:0]                  lru_hit_set_i,
  input  logic [$clog2(NUM_CORES)-1:0]                 lru_hit_core_i,
  input  logic                                         far_miss_vld_i,
  input  logic [$clog2(NUM_SETS)-1:0]                  far_miss_set_i,
  input  logic [$clog2(NUM_CORES)-1:0]                 far_miss_core_i,
  input  logic                                         epoch_i,
  output logic                                         busy_o,
  input  logic [$clog2(NUM_SETS)-1:0]                  rd_set_i,
  output logic [NUM_CORES*$clog2(ASSOC+1)-1:0]         rd_alloc_o
);
  import way_alloc_pkg::*;

  localparam int SET_W  = $clog2(NUM_SETS);
  localparam int CORE_W = $clog2(NUM_CORES);
  localparam int WAY_W  = $clog2(ASSOC + 1);
  localparam logic [SET_W-1:0] LAST_SET = SET_W'(NUM_SETS - 1);

  sweep_st_e        st_q;
  logic [SET_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SWEEP_IDLE;
      idx_q <= '0;
    end else begin
      unique case (st_q)
        SWEEP_IDLE: if (epoch_i) begin
          st_q  <= SWEEP_RUN;
          idx_q <= '0;
        end
        SWEEP_RUN: begin
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST_SET) st_q <= SWEEP_IDLE;
        end
        default: st_q <= SWEEP_IDLE;
      endcase
    end
  end

  logic sweep_act;
  assign sweep_act = (st_q == SWEEP_RUN);
  assign busy_o    = sweep_act;

  logic [NUM_CORES-1:0][CNT_W-1:0] lru_cnt, far_cnt;

  evt_cnt_bank #(.NUM_SETS(NUM_SETS), .NUM_CORES(NUM_CORES), .CNT_W(CNT_W)) u_lru_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_vld_i  (lru_hit_vld_i),
    .inc_set_i  (lru_hit_set_i),
    .inc_core_i (lru_hit_core_i),
    .clr_vld_i  (sweep_act),
    .clr_set_i  (idx_q),
    .sel_cnt_o  (lru_cnt)
  );

  evt_cnt_bank #(.NUM_SETS(NUM_SETS), .NUM_CORES(NUM_CORES), .CNT_W(CNT_W)) u_far_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inc_vld_i  (far_miss_vld_i),
    .inc_set_i  (far_miss_set_i),
    .inc_core_i (far_miss_core_i),
    .clr_vld_i  (sweep_act),
    .clr_set_i  (idx_q),
    .sel_cnt_o  (far_cnt)
  );

  logic [NUM_CORES-1:0][WAY_W-1:0] cur_ways, rd_ways;
  logic                            move_vld;
  logic [CORE_W-1:0]               recv, donor;

  way_move_select #(.NUM_CORES(NUM_CORES), .ASSOC(ASSOC), .CNT_W(CNT_W)) u_sel (
    .ways_i     (cur_ways),
    .lru_i      (lru_cnt),
    .far_i      (far_cnt),
    .move_vld_o (move_vld),
    .recv_o     (recv),
    .donor_o    (donor)
  );

  alloc_table #(.NUM_SETS(NUM_SETS), .NUM_CORES(NUM_CORES), .ASSOC(ASSOC)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_vld_i  (sweep_act && move_vld),
    .upd_set_i  (idx_q),
    .recv_i     (recv),
    .donor_i    (donor),
    .upd_ways_o (cur_ways),
    .rd_set_i   (rd_set_i),
    .rd_ways_o  (rd_ways)
  );

  assign rd_alloc_o = rd_ways;

endmodule

// File: rtl/way_alloc_chk.sv
module way_alloc_chk #(
  parameter int NUM_SETS  = 16,
  parameter int NUM_CORES = 4,
  parameter int ASSOC     = 32,
  localparam int SET_W    = $clog2(NUM_SETS),
  localparam int WAY_W    = $clog2(ASSOC + 1)
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         busy_o,
  input logic [SET_W-1:0]             rd_set_i,
  input logic [NUM_CORES*WAY_W-1:0]   rd_alloc_o
);

  int unsigned way_sum;
  int unsigned busy_len;

  always_comb begin
    way_sum = 0;
    for (int c = 0; c < NUM_CORES; c++)
      way_sum += int'(rd_alloc_o[c*WAY_W +: WAY_W]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_len <= 0;
    else if (busy_o) busy_len <= busy_len + 1;
    else             busy_len <= 0;
  end

  // R6
  sum_eq_assoc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    way_sum == ASSOC);

  // R8
  frozen_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(busy_o) && $stable(rd_set_i)) |-> $stable(rd_alloc_o));

  // R8
  sweep_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_len <= NUM_SETS);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    // R5
    min_one_way_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_alloc_o[c*WAY_W +: WAY_W] >= WAY_W'(1));

    // R6
    step_one_way_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $stable(rd_set_i) |->
        (({1'b0, rd_alloc_o[c*WAY_W +: WAY_W]} <= {1'b0, $past(rd_alloc_o[c*WAY_W +: WAY_W])} + 1'b1) &&
         ({1'b0, $past(rd_alloc_o[c*WAY_W +: WAY_W])} <= {1'b0, rd_alloc_o[c*WAY_W +: WAY_W]} + 1'b1)));
  end

endmodule

bind way_alloc_adjuster way_alloc_chk #(
  .NUM_SETS(NUM_SETS), .NUM_CORES(NUM_CORES), .ASSOC(ASSOC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .rd_set_i   (rd_set_i),
  .rd_alloc_o (rd_alloc_o)
);

// File: tb/tb_way_alloc_adjuster.sv
`timescale 1ns/1ps
module tb_way_alloc_adjuster;
  localparam int NS = 16;
  localparam int NC = 4;
  localparam int AS = 32;
  localparam int WW = 6;

  logic clk = 0, rst_n = 0;
  logic lru_vld = 0, far_vld = 0, epoch = 0;
  logic [3:0] lru_set = 0, far_set = 0, rd_set = 0;
  logic [1:0] lru_core = 0, far_core = 0;
  logic busy;
  logic [NC*WW-1:0] rd_alloc;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  way_alloc_adjuster dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lru_hit_vld_i(lru_vld), .lru_hit_set_i(lru_set), .lru_hit_core_i(lru_core),
    .far_miss_vld_i(far_vld), .far_miss_set_i(far_set), .far_miss_core_i(far_core),
    .epoch_i(epoch), .busy_o(busy), .rd_set_i(rd_set), .rd_alloc_o(rd_alloc)
  );

  // behavioural reference model
  int m_lru [NS][NC];
  int m_far [NS][NC];
  int m_ways[NS][NC];
  bit m_busy;
  int m_idx;

  task automatic model_reset();
    for (int s = 0; s < NS; s++)
      for (int c = 0; c < NC; c++) begin
        m_lru[s][c] = 0; m_far[s][c] = 0;
        m_ways[s][c] = AS / NC + ((c < AS % NC) ? 1 : 0);
      end
    m_busy = 0; m_idx = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int dec_set;
      dec_set = m_busy ? m_idx : -1;
      if (m_busy) begin
        int r, d, bg, bl;
        r = 0; bg = -1;
        for (int c = 0; c < NC; c++)
          if (m_far[dec_set][c] * (AS - m_ways[dec_set][c]) > bg) begin
            bg = m_far[dec_set][c] * (AS - m_ways[dec_set][c]); r = c;
          end
        d = -1; bl = 0;
        for (int c = 0; c < NC; c++)
          if (c != r && (d < 0 || m_lru[dec_set][c] * AS < bl)) begin
            bl = m_lru[dec_set][c] * AS; d = c;
          end
        if (bg > bl && m_ways[dec_set][d] > 1) begin
          m_ways[dec_set][r]++; m_ways[dec_set][d]--;
        end
        for (int c = 0; c < NC; c++) begin m_lru[dec_set][c] = 0; m_far[dec_set][c] = 0; end
        if (m_idx == NS - 1) m_busy = 0;
        m_idx++;
      end else if (epoch) begin
        m_busy = 1; m_idx = 0;
      end
      if (lru_vld && int'(lru_set) != dec_set && m_lru[lru_set][lru_core] < 255)
        m_lru[lru_set][lru_core]++;
      if (far_vld && int'(far_set) != dec_set && m_far[far_set][far_core] < 255)
        m_far[far_set][far_core]++;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      #2;
      n_chk++;
      if (busy !== m_busy) begin
        n_fail++;
        $display("FAIL R8 busy_o act=%0b exp=%0b", busy, m_busy);
      end
      for (int c = 0; c < NC; c++) begin
        if (int'(rd_alloc[c*WW +: WW]) != m_ways[rd_set][c]) begin
          n_fail++;
          $display("FAIL R9 model set %0d core %0d act=%0d exp=%0d",
                   rd_set, c, rd_alloc[c*WW +: WW], m_ways[rd_set][c]);
        end
      end
    end
  end

  task automatic read_chk(input int s, input int e0, input int e1, input int e2,
                          input int e3, input string req);
    int exp[NC];
    exp = '{e0, e1, e2, e3};
    @(negedge clk); rd_set = 4'(s); #3;
    for (int c = 0; c < NC; c++) begin
      n_chk++;
      if (int'(rd_alloc[c*WW +: WW]) != exp[c]) begin
        n_fail++;
        $display("FAIL %s set %0d core %0d act=%0d exp=%0d", req, s, c,
                 rd_alloc[c*WW +: WW], exp[c]);
      end
    end
  endtask

  task automatic ev_lru(input int s, input int c, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); lru_vld = 1; lru_set = 4'(s); lru_core = 2'(c);
    end
    @(negedge clk); lru_vld = 0;
  endtask

  task automatic ev_far(input int s, input int c, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); far_vld = 1; far_set = 4'(s); far_core = 2'(c);
    end
    @(negedge clk); far_vld = 0;
  endtask

  task automatic epoch_run();
    @(negedge clk); epoch = 1;
    @(negedge clk); epoch = 0;
    repeat (NS + 2) @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset split
    read_chk(0, 8, 8, 8, 8, "R1");
    read_chk(15, 8, 8, 8, 8, "R1");

    // R3 move: gain2=240 > loss1=96
    ev_far(3, 2, 10);
    ev_lru(3, 0, 5); ev_lru(3, 1, 3); ev_lru(3, 3, 4);
    // R10-style tie: gain 96 == loss 96, no move (R3 strict)
    ev_far(5, 0, 4);
    ev_lru(5, 1, 3); ev_lru(5, 2, 3); ev_lru(5, 3, 3);
    // R4 ties: receiver core1 over core3, donor core3 (loss 0)
    ev_far(6, 1, 2); ev_far(6, 3, 2);
    ev_lru(6, 0, 1); ev_lru(6, 2, 1);
    // R2 saturation: far 300 -> 255*24=6120 > 3200
    ev_far(9, 0, 300);
    ev_lru(9, 1, 100); ev_lru(9, 2, 100); ev_lru(9, 3, 100);
    epoch_run();
    read_chk(3, 8, 7, 9, 8, "R3");
    read_chk(5, 8, 8, 8, 8, "R3");
    read_chk(6, 8, 9, 8, 7, "R4");
    read_chk(9, 9, 7, 8, 8, "R2");
    read_chk(4, 8, 8, 8, 8, "R9");

    // R7 counters cleared: second epoch leaves set 3 alone
    epoch_run();
    read_chk(3, 8, 7, 9, 8, "R7");

    // R7 strobe to the visited set is dropped
    @(negedge clk); epoch = 1;
    @(negedge clk); epoch = 0;
    repeat (9) @(negedge clk);
    @(negedge clk); far_vld = 1; far_set = 4'd10; far_core = 2'd0;
    @(negedge clk); far_vld = 0;
    repeat (NS) @(negedge clk);
    epoch_run();
    read_chk(10, 8, 8, 8, 8, "R7");

    // R8 busy length, epoch during sweep ignored
    begin
      int busy_cnt;
      busy_cnt = 0;
      @(negedge clk); epoch = 1;
      for (int i = 0; i < NS + 6; i++) begin
        @(negedge clk);
        epoch = (i == 4);
        #3;
        if (busy) busy_cnt++;
      end
      epoch = 0;
      n_chk++;
      if (busy_cnt != NS) begin
        n_fail++;
        $display("FAIL R8 busy cycles act=%0d exp=%0d", busy_cnt, NS);
      end
    end

    // R5 donor floor of one way
    for (int k = 0; k < 8; k++) begin
      ev_far(7, 0, 1);
      epoch_run();
    end
    read_chk(7, 15, 1, 8, 8, "R5");
    read_chk(3, 8, 7, 9, 8, "R6");

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule